// File: doc/BRIEF.md
# APB Requester Transfer Sequencer

This block turns commands from an internal valid/ready request channel into transfers on an APB3 bus with one completer. Each command carries an address, a direction bit and write data. The block walks the bus through three phases: idle, a one-cycle setup and an access phase. The access phase lasts until the completer signals ready. When a transfer completes, the block reports it on a response channel as a single-cycle pulse. The pulse carries the read data and an error flag.

When another command is waiting at the moment a transfer completes, the sequencer goes straight into the next setup phase. The select line stays high and the bus does not return to idle. The block captures read data and the error input only on the completing cycle, so anything the completer drives during wait cycles has no effect. An option parameter can leave out error reporting for completers that lack an error output.

Top module: `apb_txn_sequencer`

## Requirements
- R1: The bus phase is encoded on psel/penable: idle is 0/0, setup is 1/0 and access is 1/1. penable is never high while psel is low.
- R2: A setup cycle always lasts exactly one cycle and is always followed by an access cycle.
- R3: While the bus is in access and pready is low, paddr, pwrite, pwdata, psel and penable keep their values on the next cycle.
- R4: If a command is accepted on the completing access cycle, the next cycle is a setup cycle (psel 1, penable 0) that carries the new address, write bit and write data.
- R5: If no command is accepted on the completing access cycle, the next cycle is idle (psel 0, penable 0).
- R6: req_ready is 1 only in idle, or in access while pready is 1. A request held during setup or during a wait cycle is not taken, and the bus outputs do not change because of it.
- R7: One cycle after a completing access cycle, rsp_valid is 1 for exactly one cycle. rsp_rdata then holds the prdata value sampled on the completing cycle. prdata on wait cycles is ignored.
- R8: rsp_err equals pslverr as sampled on the completing cycle, for both reads and writes. pslverr during wait cycles is ignored.
- R9: After reset, psel, penable, pwrite and rsp_valid are 0, and paddr and pwdata are all zeros.
- R10: A command accepted from idle appears on paddr, pwrite and pwdata in the setup cycle that follows the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus activity uses the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A command is offered |
| req_ready | output | 1 | The command is taken on this edge |
| req_addr | input | ADDR_W | Command address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Command write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data captured on completion |
| rsp_err | output | 1 | Error captured on completion |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| pready | input | 1 | Completer ready |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error |

## Verification
The sequencer is tried with single reads and writes that complete without wait states and with several wait states. It is also tried with an error completion and with two commands offered back to back. The wait-state runs show whether outputs stay frozen. During those runs the completer drives decoy data and a raised error on every non-completing cycle, which shows whether capture is limited to the completing cycle. The back-to-back run holds a second request during setup and wait cycles. It shows whether the request window opens too early and whether the bus passes from access to setup without an idle cycle.

// File: rtl/apb_seq_pkg.sv
package apb_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } bus_phase_e;
endpackage

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
   import apb_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic       pready,
   output bus_phase_e phase,
   output logic       psel,
   output logic       penable,
   output logic       complete
);
   bus_phase_e phase_nxt;

   always_comb begin
      phase_nxt = phase;
      unique case (phase)
         PH_IDLE:   if (accept) phase_nxt = PH_SETUP;
         PH_SETUP:  phase_nxt = PH_ACCESS;
         PH_ACCESS: if (pready) phase_nxt = accept ? PH_SETUP : PH_IDLE;
         default:   phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nxt;
   end

   assign psel     = (phase != PH_IDLE);
   assign penable  = (phase == PH_ACCESS);
   assign complete = (phase == PH_ACCESS) && pready;

   // R2: a setup cycle is followed by an access cycle
   assert_setup_then_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |=> (psel && penable));

   // R1: enable only with select
   assert_enable_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> psel);
endmodule

// File: rtl/seq_cmd_hold.sv
module seq_cmd_hold #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_write,
   input  logic [DATA_W-1:0] in_wdata,
   output logic [ADDR_W-1:0] paddr,
   output logic              pwrite,
   output logic [DATA_W-1:0] pwdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paddr  <= '0;
         pwrite <= 1'b0;
         pwdata <= '0;
      end else if (load) begin
         paddr  <= in_addr;
         pwrite <= in_write;
         pwdata <= in_wdata;
      end
   end
endmodule

// File: rtl/seq_rsp_capture.sv
module seq_rsp_capture #(
   parameter int DATA_W = 32,
   parameter bit ERR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              complete,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pslverr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= complete;
         if (complete) rsp_rdata <= prdata;
      end
   end

   generate
      if (ERR_EN) begin : g_err
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rsp_err <= 1'b0;
            else if (complete) rsp_err <= pslverr;
         end
      end else begin : g_no_err
         assign rsp_err = 1'b0;
      end
   endgenerate

   // R7: a response pulse only follows a completion
   assert_rsp_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(complete));
endmodule

// File: rtl/apb_txn_sequencer.sv
module apb_txn_sequencer
   import apb_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter bit ERR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              psel,
   output logic              penable,
   output logic [ADDR_W-1:0] paddr,
   output logic              pwrite,
   output logic [DATA_W-1:0] pwdata,
   input  logic              pready,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pslverr
);
   localparam int BYTE_LANES = DATA_W / 8;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("apb_txn_sequencer: ADDR_W out of range");
      end
      if ((DATA_W != 8 && DATA_W != 16 && DATA_W != 32) || BYTE_LANES * 8 != DATA_W) begin : g_bad_data
         $error("apb_txn_sequencer: DATA_W must be 8, 16 or 32");
      end
   endgenerate

   bus_phase_e phase;
   logic       complete;
   logic       accept;

   assign req_ready = (phase == PH_IDLE) || complete;
   assign accept    = req_valid && req_ready;

   seq_phase_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .pready   (pready),
      .phase    (phase),
      .psel     (psel),
      .penable  (penable),
      .complete (complete)
   );

   seq_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .in_addr  (req_addr),
      .in_write (req_write),
      .in_wdata (req_wdata),
      .paddr    (paddr),
      .pwrite   (pwrite),
      .pwdata   (pwdata)
   );

   seq_rsp_capture #(.DATA_W(DATA_W), .ERR_EN(ERR_EN)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .complete  (complete),
      .prdata    (prdata),
      .pslverr   (pslverr),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .rsp_err   (rsp_err)
   );

   // R3: outputs frozen across a wait cycle
   assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pready) |=>
         (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

   // R4: back-to-back goes straight to setup
   assert_b2b_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && req_valid) |=> (psel && !penable));

   // R5: no pending command returns to idle
   assert_done_to_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && !req_valid) |=> (!psel && !penable));

   // R6: request window only in idle or on completion
   assert_ready_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!psel || (penable && pready)));

   // R7: completion yields a response pulse next cycle
   assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready) |=> rsp_valid);
endmodule

// File: tb/test_apb_txn_sequencer.sv
`timescale 1ns/1ps
module test_apb_txn_sequencer;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_err;
   logic          psel, penable, pwrite;
   logic [AW-1:0] paddr;
   logic [DW-1:0] pwdata;
   logic          pready;
   logic [DW-1:0] prdata;
   logic          pslverr;

   int            cfg_waits = 0;
   logic          cfg_err = 1'b0;
   logic [DW-1:0] cfg_rd = '0;
   int            acc_cnt = 0;
   int            errors = 0;
   int            checks = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   // completer model: ready after cfg_waits wait cycles; decoys otherwise
   always @(posedge clk) acc_cnt <= (psel && penable) ? acc_cnt + 1 : 0;
   assign pready  = psel && penable && (acc_cnt >= cfg_waits);
   assign prdata  = pready ? cfg_rd : 32'hDEAD_BEEF;
   assign pslverr = pready ? cfg_err : 1'b1;

   apb_txn_sequencer #(.ADDR_W(AW), .DATA_W(DW)) i_apb_txn_sequencer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
      .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!psel && !penable, "R9 select/enable", {psel, penable}, 0);
      check(paddr == 0 && pwdata == 0 && !pwrite, "R9 addr/data", {16'h0, paddr}, 0);
      check(!rsp_valid, "R9 rsp_valid", rsp_valid, 0);
      check(req_ready, "R6 ready in idle", req_ready, 1);
   endtask

   // one transfer from idle with given waits, error and read value
   task automatic t_single(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] wd,
                           input int waits, input logic err, input logic [DW-1:0] rd);
      cfg_waits = waits; cfg_err = err; cfg_rd = rd;
      req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd;
      check(req_ready, "R6 ready in idle", req_ready, 1);
      step();
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd;
      check(psel && !penable, "R1 setup encoding", {psel, penable}, 2'b10);
      check(paddr == a && pwrite == w && pwdata == wd, "R10 command on bus", {16'h0, paddr}, {16'h0, a});
      check(!req_ready, "R6 not ready in setup", req_ready, 0);
      step();
      check(psel && penable, "R2 access after setup", {psel, penable}, 2'b11);
      for (int i = 0; i < waits; i++) begin
         check(!req_ready, "R6 not ready while waiting", req_ready, 0);
         step();
         check(psel && penable && paddr == a && pwrite == w && pwdata == wd,
               "R3 held during wait", {16'h0, paddr}, {16'h0, a});
         check(!rsp_valid, "R7 no early response", rsp_valid, 0);
      end
      check(pready && req_ready, "R6 ready on completion", req_ready, 1);
      step();
      check(!psel && !penable, "R5 idle after completion", {psel, penable}, 0);
      check(rsp_valid, "R7 response pulse", rsp_valid, 1);
      check(rsp_err == err, "R8 error flag", rsp_err, err);
      if (!w) check(rsp_rdata == rd, "R7 read data", rsp_rdata, rd);
      step();
      check(!rsp_valid, "R7 single-cycle pulse", rsp_valid, 0);
   endtask

   task automatic t_back_to_back();
      cfg_waits = 1; cfg_err = 1'b0; cfg_rd = 32'h0BAD_F00D;
      req_valid = 1'b1; req_addr = 16'h0100; req_write = 1'b1; req_wdata = 32'h1111_2222;
      step();
      req_addr = 16'h0204; req_write = 1'b0; req_wdata = 32'h3333_4444;
      check(!req_ready, "R6 held off in setup", req_ready, 0);
      check(paddr == 16'h0100, "R6 setup unaffected", {16'h0, paddr}, 32'h0100);
      step();
      check(!req_ready, "R6 held off in wait", req_ready, 0);
      step();
      check(paddr == 16'h0100 && pwrite, "R6 wait unaffected", {16'h0, paddr}, 32'h0100);
      check(req_ready, "R6 ready on completion", req_ready, 1);
      step();
      req_valid = 1'b0;
      check(psel && !penable, "R4 direct to setup", {psel, penable}, 2'b10);
      check(paddr == 16'h0204 && !pwrite && pwdata == 32'h3333_4444,
            "R4 new command", {16'h0, paddr}, 32'h0204);
      check(rsp_valid && !rsp_err, "R7 first response", rsp_valid, 1);
      step();
      check(!rsp_valid, "R7 pulse ends", rsp_valid, 0);
      step();
      step();
      check(rsp_valid && rsp_rdata == 32'h0BAD_F00D, "R7 second read data", rsp_rdata, 32'h0BAD_F00D);
      check(!psel, "R5 idle at end", psel, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single(16'h0010, 1'b1, 32'hA5A5_0001, 0, 1'b0, 32'h0);
      t_single(16'h0020, 1'b0, 32'h0, 0, 1'b0, 32'h1234_5678);
      t_single(16'h0030, 1'b0, 32'h0, 3, 1'b0, 32'hCAFE_0003);
      t_single(16'h0040, 1'b1, 32'h5A5A_0004, 2, 1'b1, 32'h0);
      t_single(16'h0050, 1'b0, 32'h0, 1, 1'b1, 32'h7777_0005);
      t_back_to_back();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule